// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter

This block is the central arbiter for a small shared parallel bus. Four agents each have a request line and a grant line, and both kinds of line are active low. The arbiter registers the two bus-control strobes, frame and initiator-ready. From these it works out whether the bus is idle and when a new transaction begins.

It drives exactly one grant at a time and always picks among the requesters in a fair circular order. The search pointer advances past an agent only after that agent has actually taken the bus. While another master's transaction is still running, the arbiter may move the grant to a different agent. This lets the next owner be chosen early, ready for when the bus goes idle. When nobody is requesting, the grant stays parked on the last agent that held it.

Top module: `rr_bus_arbiter`

## Requirements
- R1: No more than one bit of `gnt_no` is low in any cycle.
- R2: While `rst_ni` is low, every `gnt_no` bit is high. At the first clock edge after reset is released with no request pending, the grant parks on agent 0 (`gnt_no` = 4'b1110).
- R3: The bus counts as idle only when `frame_ni` and `irdy_ni` were both sampled high. If `frame_ni` goes low while the previous sample of `irdy_ni` was still low, that is not a transaction start, and the rotation pointer keeps its value.
- R4: While the request pattern stays the same and no new transaction starts, the grant stays on the same agent, including while `frame_ni` is held low.
- R5: The grant goes to the first low request found when searching upward from the rotation pointer (agent index = bit index of `req_ni`). The search wraps from agent 3 back to agent 0, and the pointer is 0 after reset.
- R6: A transaction start is `frame_ni` sampled low at edge k, with both strobes sampled high at edge k-1. The agent that started it is the one that held the grant just before edge k. At edge k+1 the pointer becomes that agent plus one (modulo 4). The grant chosen at edge k+2 reflects the new pointer.
- R7: When no request is low, `gnt_no` keeps its previous value.
- R8: The grant may move to another agent while the bus is busy. Any such move deasserts the old grant and asserts the new one in the same cycle.
- R9: If the granted agent raises its request and others are still requesting, the grant moves to one of those others at the next edge.
- R10: `gnt_no` is a register output. A change in `req_ni` sampled at one rising edge appears on `gnt_no` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | AGENTS | Agent requests, active low |
| frame_ni | input | 1 | Bus frame strobe, active low |
| irdy_ni | input | 1 | Initiator-ready strobe, active low |
| gnt_no | output | AGENTS | Agent grants, active low, registered |

## Verification
The assertions assume that requests and both strobes are synchronous to `clk_i` and carry only 0 or 1 once reset is released. The hold property assumes that a stable request pattern means nothing changed at the arbiter's inputs. The stimulus changes every input only on the falling clock edge and drives only defined levels. The random phase freely mixes idle, busy and back-to-back strobe patterns, including starts by agents that hold no grant. These are patterns the arbiter has to tolerate without losing the single-grant rule.

// File: rtl/arb_pkg.sv
package arb_pkg;
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  output logic txn_start_o
);
  logic frame_q, irdy_q, idle_prev_q;

  // strobes land in flops first; arbitration sees only registered copies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q     <= 1'b1;
      irdy_q      <= 1'b1;
      idle_prev_q <= 1'b1;
    end else begin
      frame_q     <= frame_ni;
      irdy_q      <= irdy_ni;
      idle_prev_q <= frame_q & irdy_q;
    end
  end

  assign txn_start_o = idle_prev_q & ~frame_q;

  p_busy_irdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irdy_q |=> !txn_start_o);
endmodule

// File: rtl/rr_select.sv
module rr_select #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    int unsigned s;
    any_o = |req_i;
    idx_o = '0;
    // walk offsets high to low so the nearest request wins
    for (int off = N - 1; off >= 0; off--) begin
      s = int'(ptr_i) + off;
      if (s >= N) s = s - N;
      if (req_i[s]) idx_o = W'(s);
    end
  end
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int unsigned AGENTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AGENTS-1:0] req_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  output logic [AGENTS-1:0] gnt_no
);
  import arb_pkg::*;
  localparam int unsigned IDXW = (AGENTS > 1) ? $clog2(AGENTS) : 1;

  logic [AGENTS-1:0] req_act, gnt_nq;
  logic [IDXW-1:0]   ptr_q, owner_q, gnt_idx_q, pick_idx, next_idx;
  logic              pick_any, txn_start;

  assign req_act = ~req_ni;

  bus_phase_tracker u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_ni    (frame_ni),
    .irdy_ni     (irdy_ni),
    .txn_start_o (txn_start)
  );

  rr_select #(.N(AGENTS), .W(IDXW)) u_sel (
    .req_i (req_act),
    .ptr_i (ptr_q),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  // park on current holder when nobody asks
  assign next_idx = pick_any ? pick_idx : gnt_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      owner_q   <= '0;
      gnt_idx_q <= '0;
      gnt_nq    <= '1;
    end else begin
      owner_q   <= gnt_idx_q;  // holder seen by agents when strobes were sampled
      gnt_idx_q <= next_idx;
      gnt_nq    <= ~(AGENTS'(1) << next_idx);
      if (txn_start) ptr_q <= IDXW'(wrap_next(int'(owner_q), AGENTS));
    end
  end

  assign gnt_no = gnt_nq;

  p_one_grant_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~gnt_no));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ni == $past(req_ni) && ptr_q == $past(ptr_q) && gnt_no != '1) |=> $stable(gnt_no));

  p_to_requester_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ni != '1) |=> ((~gnt_no & ~$past(req_ni)) != '0));

  p_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ni == '1 && gnt_no != '1) |=> $stable(gnt_no));

  p_handoff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gnt_no) |-> ($countones(gnt_no ^ $past(gnt_no)) <= 2));
endmodule

// File: tb/rr_bus_arbiter_bench.sv
module rr_bus_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] req_n = 4'hF;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [3:0] gnt_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_frame, m_irdy, m_idle_prev, m_vld;
  int m_ptr, m_owner, m_gidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_bus_arbiter u_rr_bus_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n),
    .frame_ni(frame_n), .irdy_ni(irdy_n), .gnt_no(gnt_n)
  );

  function automatic int pick(input logic [3:0] rn, input int p);
    for (int off = 0; off < 4; off++) begin
      int i = (p + off) % 4;
      if (!rn[i]) return i;
    end
    return -1;
  endfunction

  function automatic logic [3:0] model_gnt();
    return m_vld ? ~(4'b0001 << m_gidx) : 4'hF;
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      m_frame = 1; m_irdy = 1; m_idle_prev = 1; m_vld = 0;
      m_ptr = 0; m_owner = 0; m_gidx = 0;
    end else begin
      bit start = m_idle_prev & ~m_frame;
      int np = start ? (m_owner + 1) % 4 : m_ptr;
      int pk = pick(req_n, m_ptr);
      m_owner = m_gidx;
      if (pk >= 0) m_gidx = pk;
      m_vld = 1;
      m_ptr = np;
      m_idle_prev = m_frame & m_irdy;
      m_frame = frame_n;
      m_irdy = irdy_n;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    checks++;
    if (gnt_n !== exp) begin
      errors++;
      $display("FAIL %s: gnt_no=%b expected %b", tag, gnt_n, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_frame = 1; m_irdy = 1; m_idle_prev = 1; m_vld = 0;
    m_ptr = 0; m_owner = 0; m_gidx = 0;
    #1 rst_n = 1'b0;
    repeat (3) cyc();
    chk(4'hF, "R2 reset quiet");
    rst_n = 1'b1;
    cyc();
    chk(4'b1110, "R2 park agent0");

    req_n = 4'b0101;                 // agents 1 and 3
    cyc();
    chk(4'b1101, "R10 one-edge latency");
    repeat (3) cyc();
    chk(4'b1101, "R4 stable while idle");

    frame_n = 1'b0;                  // agent 1 starts
    cyc(); chk(4'b1101, "R6 edge k");
    cyc(); chk(4'b1101, "R6 edge k+1");
    cyc(); chk(4'b0111, "R8 preempt to agent3 while busy");
    repeat (4) cyc();
    chk(4'b0111, "R4 stable while frame low");

    req_n = 4'b1101;                 // agent 3 withdraws
    cyc(); chk(4'b1101, "R9 rearbitrate");
    req_n = 4'hF;
    repeat (2) cyc();
    chk(4'b1101, "R7 park on last");

    req_n = 4'b1100;                 // agents 0,1; pointer at 2
    frame_n = 1'b1; irdy_n = 1'b0;
    cyc(); chk(4'b1110, "R5 wrap to agent0");
    cyc();
    frame_n = 1'b0;                  // back-to-back, bus never idle
    repeat (3) cyc();
    chk(4'b1110, "R3 no start without idle");
    frame_n = 1'b1; irdy_n = 1'b1;
    repeat (2) cyc();
    chk(model_gnt(), "R5 model sync");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 4 == 0) req_n = 4'($urandom);
      frame_n = ($urandom % 3) != 0;
      irdy_n  = ($urandom % 3) != 0;
      cyc();
      chk(model_gnt(), "R5 random");
      checks++;
      if ($countones(~gnt_n) > 1) begin
        errors++;
        $display("FAIL R1: gnt_no=%b expected at most one low", gnt_n);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule